// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block turns single-cycle host requests into correctly timed read and write cycles on a byte-wide asynchronous static RAM with active-low chip select, write strobe and output strobe. The host raises a request strobe for one clock with a direction bit, a 15-bit byte address (32,768 locations) and, for writes, a data byte. The controller presents the address one cycle ahead of any strobe, holds the strobes for a programmable number of clock cycles, and answers with a one-cycle done pulse. For a read, it also returns the byte it captured in the last access cycle.

Write windows are formed by chip select and write strobe being low together. The output strobe is held high for the whole write. The controller drives the shared data bus only while the memory's outputs are off, and releases it one cycle after the write strobe rises. A programmable recovery gap follows every write before the done pulse, so no new cycle can start too early. A power-fail inhibit input from outside makes any request finish at once with an error flag, and no strobe moves. The bidirectional data bus is split into out, in and enable signals.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: During and after reset, until the first request, the chip select, write strobe and output strobe are high (inactive), the bus enable is low, and done and error are low.
- R2: A read holds chip select and output strobe low with the write strobe high for exactly RD_CYC cycles. The done pulse arrives RD_CYC+2 cycles after the request is sampled, and the read data equals the byte the memory presented in the last strobe cycle.
- R3: A write holds chip select and write strobe low together for exactly WR_CYC cycles, and the output strobe stays high whenever the write strobe is low.
- R4: The address output takes the request's address one cycle before chip select falls and does not change while chip select is low.
- R5: The bus enable is high only while the output strobe is high. It rises in the setup cycle of a write, stays high until one cycle after the write strobe rises, and is low in every read.
- R6: After a write, the write strobe stays high for at least REC_CYC cycles before chip select can fall again. The write's done pulse arrives WR_CYC+REC_CYC+2 cycles after the request is sampled.
- R7: A request sampled while the inhibit input is high gets done with the error flag set one cycle later. No strobe falls, and the memory contents are left unchanged.
- R8: Done is a single-cycle pulse, and the error flag is high only together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle request strobe, accepted only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write data |
| inhibit | input | 1 | Power-fail write protect; rejects requests |
| rsp_rdata | output | 8 | Byte captured by the last read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request rejected because of inhibit |
| mem_addr | output | 15 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | High when the controller drives the data bus |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
Some properties are checked on every cycle. The write and output strobes are never low together, and neither is low without chip select. The address holds still while chip select stays low. The bus enable never overlaps an active output strobe. Done lasts one cycle, an error only comes with done, and an inhibited request leaves chip select high. Other properties need the bench's scenarios. These are the exact strobe lengths, the done latencies, the recovery gap between a write and the following read, and data that round-trips through a memory model that only presents valid bytes late in the access. The same goes for proof that an inhibited write leaves the stored byte unchanged.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_RECOV = 3'd4
  } ctrl_state_t;
endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

  AST_TMR_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (!load && !zero) |=> (cnt == $past(cnt) - 1'b1)); // R2
endmodule

// File: rtl/sram_io_regs.sv
module sram_io_regs #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_req,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic          cap_rd,
  input  logic [DW-1:0] in_rdata,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_wdata,
  output logic [DW-1:0] out_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_addr  <= '0;
      out_wdata <= '0;
      out_rdata <= '0;
    end else begin
      if (cap_req) begin
        out_addr  <= in_addr;
        out_wdata <= in_wdata;
      end
      if (cap_rd) begin
        out_rdata <= in_rdata;
      end
    end
  end

  AST_CAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(cap_req && cap_rd)); // R4
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW      = 15,
  parameter int DW      = 8,
  parameter int RD_CYC  = 3,
  parameter int WR_CYC  = 2,
  parameter int REC_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          inhibit,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int MAXC = (RD_CYC > WR_CYC) ?
                        ((RD_CYC > REC_CYC) ? RD_CYC : REC_CYC) :
                        ((WR_CYC > REC_CYC) ? WR_CYC : REC_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RD_LD  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WR_LD  = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] REC_LD = CW'(REC_CYC - 1);

  ctrl_state_t   st;
  logic          is_wr;
  logic          tmr_zero;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          cap_req;
  logic          cap_rd;

  assign cap_req = (st == ST_IDLE) && req && !inhibit;
  assign cap_rd  = (st == ST_READ) && tmr_zero;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (st == ST_SETUP) begin
      tmr_load = 1'b1;
      tmr_val  = is_wr ? WR_LD : RD_LD;
    end else if (st == ST_WRITE && tmr_zero) begin
      tmr_load = 1'b1;
      tmr_val  = REC_LD;
    end
  end

  sram_cyc_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_io_regs #(.AW(AW), .DW(DW)) u_io (
    .clk       (clk),
    .rst       (rst),
    .cap_req   (cap_req),
    .in_addr   (req_addr),
    .in_wdata  (req_wdata),
    .cap_rd    (cap_rd),
    .in_rdata  (mem_dq_in),
    .out_addr  (mem_addr),
    .out_wdata (mem_dq_out),
    .out_rdata (rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      is_wr     <= 1'b0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req) begin
            if (inhibit) begin
              rsp_done <= 1'b1;
              rsp_err  <= 1'b1;
            end else begin
              st        <= ST_SETUP;
              is_wr     <= req_wr;
              mem_dq_oe <= req_wr;
            end
          end
        end
        ST_SETUP: begin
          mem_ce_n <= 1'b0;
          if (is_wr) begin
            mem_we_n <= 1'b0;
            st       <= ST_WRITE;
          end else begin
            mem_oe_n <= 1'b0;
            st       <= ST_READ;
          end
        end
        ST_READ: begin
          if (tmr_zero) begin
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            rsp_done <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        ST_WRITE: begin
          if (tmr_zero) begin
            mem_ce_n <= 1'b1;
            mem_we_n <= 1'b1;
            st       <= ST_RECOV;
          end
        end
        ST_RECOV: begin
          mem_dq_oe <= 1'b0;
          if (tmr_zero) begin
            rsp_done <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n)); // R3
  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n || !mem_oe_n) |-> !mem_ce_n); // R2
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R4
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_done); // R8
  AST_INHIBIT_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && req && inhibit) |=> (mem_ce_n && rsp_err)); // R7
endmodule

// File: tb/sim_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_sram_cycle_ctrl;
  localparam int RD  = 3;
  localparam int WR  = 2;
  localparam int REC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        inhibit = 1'b0;
  logic [7:0]  rsp_rdata;
  logic        rsp_done, rsp_err;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  always #4 clk = ~clk;

  sram_cycle_ctrl #(.RD_CYC(RD), .WR_CYC(WR), .REC_CYC(REC)) u0 (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .inhibit(inhibit), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: valid data only late in the read strobe
  logic [7:0] mem [0:255];
  int         rd_cnt = 0;
  always @(posedge clk) rd_cnt <= (!mem_ce_n && !mem_oe_n) ? rd_cnt + 1 : 0;
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && rd_cnt >= RD - 1) ? mem[mem_addr[7:0]] : 8'hEE;

  // monitors sampled at negedge
  logic       wpend = 1'b0;
  logic [7:0] wbuf;
  logic [14:0] waddr, ce_addr;
  int  we_len = 0, oe_len = 0, last_we_len = 0, last_oe_len = 0;
  int  gap = 0, last_gap = 0;
  bit  gap_run = 1'b0;
  int  v_weoe = 0, v_addr = 0, v_bus = 0, v_wbus = 0, ce_cnt = 0;
  bit  prev_ce = 1'b1, prev_we = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_we_n && !mem_oe_n) v_weoe++;
      if (mem_dq_oe && !mem_oe_n) v_bus++;
      if (!mem_ce_n && !prev_ce) begin
        if (mem_addr != ce_addr) v_addr++;
      end
      if (!mem_ce_n) ce_addr = mem_addr;
      if (!mem_ce_n && prev_ce) ce_cnt++;
      if (!mem_ce_n && !mem_we_n) begin
        we_len++;
        if (!mem_dq_oe) v_wbus++;
        wbuf = mem_dq_out; waddr = mem_addr; wpend = 1'b1;
      end else begin
        if (we_len != 0) last_we_len = we_len;
        we_len = 0;
        if (wpend) begin mem[waddr[7:0]] = wbuf; wpend = 1'b0; end
      end
      if (!mem_ce_n && !mem_oe_n) oe_len++;
      else begin
        if (oe_len != 0) last_oe_len = oe_len;
        oe_len = 0;
      end
      if (mem_we_n && !prev_we) begin gap_run = 1'b1; gap = 0; end
      if (gap_run) begin
        if (!mem_ce_n) begin last_gap = gap; gap_run = 1'b0; end
        else gap++;
      end
      prev_ce = mem_ce_n;
      prev_we = mem_we_n;
    end
  end

  task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d,
                       output int lat, output logic [7:0] rd, output bit er);
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    while (!rsp_done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    er = rsp_err;
    @(negedge clk);
    chk(!rsp_done, "R8 done single pulse", rsp_done, 0);
  endtask

  localparam logic [31:0] VEC [0:5] = '{
    {1'b1, 15'h0012, 8'hA5, 8'h00},
    {1'b1, 15'h7F34, 8'h3C, 8'h00},
    {1'b0, 15'h0012, 8'h00, 8'hA5},
    {1'b0, 15'h7F34, 8'h00, 8'h3C},
    {1'b1, 15'h0012, 8'h5A, 8'h00},
    {1'b0, 15'h0012, 8'h00, 8'h5A}
  };

  initial begin
    int lat; logic [7:0] rd; bit er; int ce0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high in reset", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    chk(!mem_dq_oe && !rsp_done && !rsp_err, "R1 bus/done low in reset", {mem_dq_oe, rsp_done, rsp_err}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_done, "R1 idle after reset",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done}, 5'b11100);

    for (int i = 0; i < 6; i++) begin
      do_op(VEC[i][31], VEC[i][30:16], VEC[i][15:8], lat, rd, er);
      chk(!er, "R8 no error on normal op", er, 0);
      if (VEC[i][31]) begin
        chk(lat == WR + REC + 2, "R6 write done latency", lat, WR + REC + 2);
        chk(last_we_len == WR, "R3 write strobe length", last_we_len, WR);
      end else begin
        chk(lat == RD + 2, "R2 read done latency", lat, RD + 2);
        chk(last_oe_len == RD, "R2 read strobe length", last_oe_len, RD);
        chk(rd == VEC[i][7:0], "R2 read data", rd, VEC[i][7:0]);
        if (i > 0 && VEC[i-1][31])
          chk(last_gap >= REC, "R6 recovery gap before read", last_gap, REC);
      end
    end

    // R7: inhibited write leaves memory unchanged, no strobe
    inhibit = 1'b1;
    ce0 = ce_cnt;
    do_op(1'b1, 15'h0012, 8'hFF, lat, rd, er);
    chk(er, "R7 error flag on inhibit", er, 1);
    chk(lat == 1, "R7 inhibit done latency", lat, 1);
    chk(ce_cnt == ce0, "R7 no strobe under inhibit", ce_cnt - ce0, 0);
    inhibit = 1'b0;
    do_op(1'b0, 15'h0012, 8'h00, lat, rd, er);
    chk(rd == 8'h5A, "R7 memory unchanged after inhibit", rd, 8'h5A);

    // R5: write then read back-to-back, bus released
    do_op(1'b1, 15'h00C7, 8'h81, lat, rd, er);
    chk(!mem_dq_oe, "R5 bus released after write", mem_dq_oe, 0);
    do_op(1'b0, 15'h00C7, 8'h00, lat, rd, er);
    chk(rd == 8'h81, "R2 back-to-back read data", rd, 8'h81);
    chk(last_gap >= REC, "R6 gap write-to-read", last_gap, REC);

    chk(v_weoe == 0, "R3 WE and OE never both low", v_weoe, 0);
    chk(v_addr == 0, "R4 address stable while CE low", v_addr, 0);
    chk(v_bus == 0, "R5 no bus drive with OE low", v_bus, 0);
    chk(v_wbus == 0, "R5 bus driven during write window", v_wbus, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule